// File: doc/BRIEF.md
# SD/MMC Card Identification Sequencer

This block brings a freshly powered memory card from the idle state to the transfer state without software involvement. It drives a command-issue port (index, 32-bit argument, valid/ready handshake) and consumes a response port that reports completion, a response timeout or a transport fault together with up to 128 response bits. A single state machine serves both SD and MMC cards. The echo of the interface-condition command and the presence or absence of a reply to the SD operating-condition command decide which branch is taken.

After a `start` pulse the sequencer resets the card, classifies it, polls the operating condition until the card reports power-up complete, then reads the card ID, sets up the relative address, fetches the card-specific data, selects the card and polls its status until it reports the transfer state. The results are held on the outputs until the next `start`: card type, high-capacity flag, relative address, block length and MMC version. Every failure path ends in a terminal state with its own error code. An overall time budget, given in milliseconds and scaled by the clock rate, bounds the whole sequence.

Top module: `sd_card_ident`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `done`, `busy` and `cmd_valid` are 0 and `err_code` is 0.
- R2: A sequence begins with index 0 and argument 0. The next command is index 8 with argument 0x000001AA.
- R3: The index-8 result selects the branch. A timeout means an SD card without high-capacity support, and its index-41 argument has bit 30 clear. A reply whose bits 7:0 are 0xAA means an SD card with bit 30 set in the index-41 argument. Any other reply goes to the MMC branch.
- R4: The SD loop repeats index 55 (argument 0) followed by index 41 (argument `VOLT_MASK`, default 0x00FF8000, plus the bit from R3) until reply bit 31 is set. A timeout on index 41 moves to the MMC branch. That branch sends index 0 again, then repeats index 1 with `VOLT_MASK` | 0x40000000 until reply bit 31 is set.
- R5: `high_cap` equals bit 30 of the last operating-condition reply. `card_type` is 1 for SD and 2 for MMC.
- R6: Index 2 is sent with argument 0. Index 3 is sent with `FIXED_RCA` (default 0x0001) in argument bits 31:16. For SD, `rca` takes reply bits 31:16 of index 3; for MMC it stays `FIXED_RCA`. Indexes 9, 7 and 13 carry `rca` in argument bits 31:16.
- R7: `blk_len` is 2 to the power of response bits 75:72 (word 2, bits 11:8), capped at 512. For MMC, `mmc_ver` is response bits 117:114 (word 3, bits 21:18), capped at 4. For SD it is 0.
- R8: Index 13 is repeated until reply bits 12:9 equal 4. The sequencer then raises `done`.
- R9: An index-13 reply with any `STATUS_ERR_MASK` bit set (bit 19 among them) ends with `err_code` 7.
- R10: A failed reply ends in a terminal error, with the code set by where it failed. Index 0 at the start gives code 1. A fault on index 8 gives 2. A fault on index 55 or 41 gives 3. A failure on the MMC reset or on index 1 gives 4. A failure on index 2, 3 or 9 gives 5. A failure on index 7 or 13 gives 6.
- R11: If the sequence is still running when `CLK_KHZ`×`LIMIT_MS` cycles have passed since `start`, it ends with `err_code` 8.
- R12: At most one command is outstanding. `cmd_valid` does not rise before the previous reply arrives. Index and argument stay stable while `cmd_valid` is high and `cmd_ready` is low.
- R13: `done` and a nonzero `err_code` never occur together. Terminal results hold until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when not busy) |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Reply strobe, one cycle |
| rsp_code | input | 2 | 0 ok, 1 timeout, 2 fault |
| rsp_data | input | 128 | Reply bits, word k at bits 32k+31:32k |
| busy | output | 1 | Sequence running |
| done | output | 1 | Card reached transfer state |
| err_code | output | 4 | Terminal error code, 0 if none |
| card_type | output | 2 | 0 none, 1 SD, 2 MMC |
| high_cap | output | 1 | High-capacity card |
| rca | output | 16 | Relative card address |
| blk_len | output | MAX_BLK_LOG2+1 | Block length in bytes |
| mmc_ver | output | 3 | MMC version field, capped |

## Verification
The assertions assume that the command port honours one transaction at a time. A reply strobe arrives only after a command has been accepted, and never while nothing is outstanding. `start` is treated as meaningful only outside a running sequence. The bench's card model drives `cmd_ready` high at all times. It answers each accepted command with a single strobe two cycles later, driven on the falling edge, and it never produces a spontaneous reply. The bench resets between scenarios, so a late reply from an aborted command cannot fall into the next run.

// File: rtl/sd_id_pkg.sv
package sd_id_pkg;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_TIMEOUT = 2'd1,
        RSP_FAULT   = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        CARD_NONE = 2'd0,
        CARD_SD   = 2'd1,
        CARD_MMC  = 2'd2
    } card_e;

    typedef enum logic [3:0] {
        FAIL_NONE     = 4'd0,
        FAIL_RESET    = 4'd1,
        FAIL_IFCOND   = 4'd2,
        FAIL_SD_OP    = 4'd3,
        FAIL_MMC_OP   = 4'd4,
        FAIL_IDENT    = 4'd5,
        FAIL_SELECT   = 4'd6,
        FAIL_STATUS   = 4'd7,
        FAIL_TIME     = 4'd8
    } fail_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RST0, ST_IFCOND, ST_APP, ST_SDOP, ST_MRST, ST_MOP,
        ST_CID, ST_RCA, ST_CSD, ST_SEL, ST_STAT, ST_DONE, ST_FAIL
    } seq_state_e;

    localparam logic [5:0] IDX_GO_IDLE  = 6'd0;
    localparam logic [5:0] IDX_MMC_OP   = 6'd1;
    localparam logic [5:0] IDX_ALL_CID  = 6'd2;
    localparam logic [5:0] IDX_REL_ADDR = 6'd3;
    localparam logic [5:0] IDX_SELECT   = 6'd7;
    localparam logic [5:0] IDX_IF_COND  = 6'd8;
    localparam logic [5:0] IDX_CSD      = 6'd9;
    localparam logic [5:0] IDX_STATUS   = 6'd13;
    localparam logic [5:0] IDX_SD_OP    = 6'd41;
    localparam logic [5:0] IDX_APP      = 6'd55;

    localparam logic [31:0] IF_COND_ARG  = 32'h0000_01AA;
    localparam logic [7:0]  ECHO_PATTERN = 8'hAA;
    localparam logic [31:0] CAP_REQ_BIT  = 32'h4000_0000;
    localparam logic [3:0]  TRAN_STATE   = 4'd4;
    localparam logic [2:0]  MAX_MMC_VER  = 3'd4;

    typedef struct packed {
        logic        ocr_busy;
        logic        ocr_ccs;
        logic        echo_ok;
        logic [15:0] new_rca;
        logic [3:0]  cur_state;
        logic        stat_err;
        logic [3:0]  blk_log2;
        logic [2:0]  mmc_ver;
    } rsp_fields_t;

    function automatic logic [5:0] index_of(seq_state_e s);
        case (s)
            ST_RST0, ST_MRST: return IDX_GO_IDLE;
            ST_IFCOND:        return IDX_IF_COND;
            ST_APP:           return IDX_APP;
            ST_SDOP:          return IDX_SD_OP;
            ST_MOP:           return IDX_MMC_OP;
            ST_CID:           return IDX_ALL_CID;
            ST_RCA:           return IDX_REL_ADDR;
            ST_CSD:           return IDX_CSD;
            ST_SEL:           return IDX_SELECT;
            ST_STAT:          return IDX_STATUS;
            default:          return IDX_GO_IDLE;
        endcase
    endfunction

    function automatic logic is_running(seq_state_e s);
        return !(s == ST_IDLE || s == ST_DONE || s == ST_FAIL);
    endfunction

endpackage

// File: rtl/sd_id_issuer.sv
module sd_id_issuer
    import sd_id_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         req,
    input  logic [5:0]   req_index,
    input  logic [31:0]  req_arg,
    output logic         idle,
    output logic         cmd_valid,
    input  logic         cmd_ready,
    output logic [5:0]   cmd_index,
    output logic [31:0]  cmd_arg,
    input  logic         rsp_valid,
    input  logic [1:0]   rsp_code,
    input  logic [127:0] rsp_data,
    output logic         got,
    output logic [1:0]   got_code,
    output logic [127:0] got_data
);
    typedef enum logic [1:0] {I_IDLE, I_SEND, I_WAIT} iss_state_e;

    iss_state_e st_q;
    logic [5:0]  idx_q;
    logic [31:0] arg_q;

    assign idle      = (st_q == I_IDLE);
    assign cmd_valid = (st_q == I_SEND) && !clear;
    assign cmd_index = idx_q;
    assign cmd_arg   = arg_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st_q     <= I_IDLE;
            idx_q    <= '0;
            arg_q    <= '0;
            got      <= 1'b0;
            got_code <= '0;
            got_data <= '0;
        end else begin
            got <= 1'b0;
            case (st_q)
                I_IDLE: if (req) begin
                    idx_q <= req_index;
                    arg_q <= req_arg;
                    st_q  <= I_SEND;
                end
                I_SEND: if (cmd_ready) st_q <= I_WAIT;
                I_WAIT: if (rsp_valid) begin
                    got      <= 1'b1;
                    got_code <= rsp_code;
                    got_data <= rsp_data;
                    st_q     <= I_IDLE;
                end
                default: st_q <= I_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sd_id_decode.sv
module sd_id_decode
    import sd_id_pkg::*;
#(
    parameter int          MAX_BLK_LOG2    = 9,
    parameter logic [31:0] STATUS_ERR_MASK = 32'hFDF9_8008
) (
    input  logic [127:0] data,
    output rsp_fields_t  f
);
    logic [3:0] blk_field;
    logic [3:0] ver_field;

    always_comb begin
        blk_field   = data[64+11:64+8];
        ver_field   = data[96+21:96+18];
        f.ocr_busy  = data[31];
        f.ocr_ccs   = data[30];
        f.echo_ok   = (data[7:0] == ECHO_PATTERN);
        f.new_rca   = data[31:16];
        f.cur_state = data[12:9];
        f.stat_err  = |(data[31:0] & STATUS_ERR_MASK);
        f.blk_log2  = (int'(blk_field) > MAX_BLK_LOG2) ? 4'(MAX_BLK_LOG2) : blk_field;
        f.mmc_ver   = (ver_field > 4'(MAX_MMC_VER)) ? MAX_MMC_VER : ver_field[2:0];
    end
endmodule

// File: rtl/sd_id_timer.sv
module sd_id_timer #(
    parameter int unsigned CLK_KHZ  = 125000,
    parameter int unsigned LIMIT_MS = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam longint unsigned LIMIT = longint'(CLK_KHZ) * longint'(LIMIT_MS);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    assign expired = run && (cnt_q == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sd_card_ident.sv
module sd_card_ident
    import sd_id_pkg::*;
#(
    parameter int unsigned CLK_KHZ         = 125000,
    parameter int unsigned LIMIT_MS        = 20000,
    parameter logic [31:0] VOLT_MASK       = 32'h00FF_8000,
    parameter logic [15:0] FIXED_RCA       = 16'h0001,
    parameter logic [31:0] STATUS_ERR_MASK = 32'hFDF9_8008,
    parameter int          MAX_BLK_LOG2    = 9,
    localparam int         BLK_W           = MAX_BLK_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [5:0]       cmd_index,
    output logic [31:0]      cmd_arg,
    input  logic             rsp_valid,
    input  logic [1:0]       rsp_code,
    input  logic [127:0]     rsp_data,
    output logic             busy,
    output logic             done,
    output logic [3:0]       err_code,
    output logic [1:0]       card_type,
    output logic             high_cap,
    output logic [15:0]      rca,
    output logic [BLK_W-1:0] blk_len,
    output logic [2:0]       mmc_ver
);
    seq_state_e  state_q;
    logic        pend_q;
    logic        v2_q;
    card_e       type_q;
    fail_e       fail_q;
    logic        hc_q;
    logic [15:0] rca_q;
    logic [BLK_W-1:0] blk_q;
    logic [2:0]  ver_q;

    logic         running;
    logic         expired;
    logic         iss_idle;
    logic         iss_req;
    logic         got;
    logic [1:0]   got_code;
    logic [127:0] got_data;
    logic [31:0]  next_arg;
    rsp_fields_t  fld;
    logic         r_ok;
    logic         r_tmo;

    assign running = is_running(state_q);
    assign iss_req = running && !pend_q && iss_idle && !expired;
    assign r_ok    = (got_code == RSP_OK);
    assign r_tmo   = (got_code == RSP_TIMEOUT);

    always_comb begin
        case (state_q)
            ST_IFCOND: next_arg = IF_COND_ARG;
            ST_SDOP:   next_arg = VOLT_MASK | (v2_q ? CAP_REQ_BIT : 32'h0);
            ST_MOP:    next_arg = VOLT_MASK | CAP_REQ_BIT;
            ST_RCA:    next_arg = {FIXED_RCA, 16'h0000};
            ST_CSD, ST_SEL, ST_STAT: next_arg = {rca_q, 16'h0000};
            default:   next_arg = 32'h0;
        endcase
    end

    sd_id_issuer i_issuer (
        .clk       (clk),
        .rst       (rst),
        .clear     (!running),
        .req       (iss_req),
        .req_index (index_of(state_q)),
        .req_arg   (next_arg),
        .idle      (iss_idle),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_index (cmd_index),
        .cmd_arg   (cmd_arg),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .rsp_data  (rsp_data),
        .got       (got),
        .got_code  (got_code),
        .got_data  (got_data)
    );

    sd_id_decode #(
        .MAX_BLK_LOG2    (MAX_BLK_LOG2),
        .STATUS_ERR_MASK (STATUS_ERR_MASK)
    ) i_decode (
        .data (got_data),
        .f    (fld)
    );

    sd_id_timer #(
        .CLK_KHZ  (CLK_KHZ),
        .LIMIT_MS (LIMIT_MS)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            v2_q    <= 1'b0;
            type_q  <= CARD_NONE;
            fail_q  <= FAIL_NONE;
            hc_q    <= 1'b0;
            rca_q   <= '0;
            blk_q   <= '0;
            ver_q   <= '0;
        end else if (!running) begin
            if (start) begin
                state_q <= ST_RST0;
                pend_q  <= 1'b0;
                v2_q    <= 1'b0;
                type_q  <= CARD_NONE;
                fail_q  <= FAIL_NONE;
                hc_q    <= 1'b0;
                rca_q   <= '0;
                blk_q   <= '0;
                ver_q   <= '0;
            end
        end else if (expired) begin
            state_q <= ST_FAIL;
            fail_q  <= FAIL_TIME;
            pend_q  <= 1'b0;
        end else begin
            if (iss_req) pend_q <= 1'b1;
            if (got) begin
                pend_q <= 1'b0;
                case (state_q)
                    ST_RST0: begin
                        if (r_ok) state_q <= ST_IFCOND;
                        else begin state_q <= ST_FAIL; fail_q <= FAIL_RESET; end
                    end
                    ST_IFCOND: begin
                        if (r_tmo) begin
                            v2_q    <= 1'b0;
                            state_q <= ST_APP;
                        end else if (r_ok && fld.echo_ok) begin
                            v2_q    <= 1'b1;
                            state_q <= ST_APP;
                        end else if (r_ok) begin
                            state_q <= ST_MRST;
                        end else begin
                            state_q <= ST_FAIL; fail_q <= FAIL_IFCOND;
                        end
                    end
                    ST_APP: begin
                        if (got_code == RSP_FAULT) begin
                            state_q <= ST_FAIL; fail_q <= FAIL_SD_OP;
                        end else state_q <= ST_SDOP;
                    end
                    ST_SDOP: begin
                        if (r_tmo) state_q <= ST_MRST;
                        else if (!r_ok) begin
                            state_q <= ST_FAIL; fail_q <= FAIL_SD_OP;
                        end else if (fld.ocr_busy) begin
                            hc_q    <= fld.ocr_ccs;
                            type_q  <= CARD_SD;
                            state_q <= ST_CID;
                        end else state_q <= ST_APP;
                    end
                    ST_MRST: begin
                        if (r_ok) state_q <= ST_MOP;
                        else begin state_q <= ST_FAIL; fail_q <= FAIL_MMC_OP; end
                    end
                    ST_MOP: begin
                        if (!r_ok) begin
                            state_q <= ST_FAIL; fail_q <= FAIL_MMC_OP;
                        end else if (fld.ocr_busy) begin
                            hc_q    <= fld.ocr_ccs;
                            type_q  <= CARD_MMC;
                            state_q <= ST_CID;
                        end
                    end
                    ST_CID: begin
                        if (r_ok) begin
                            rca_q   <= FIXED_RCA;
                            state_q <= ST_RCA;
                        end else begin state_q <= ST_FAIL; fail_q <= FAIL_IDENT; end
                    end
                    ST_RCA: begin
                        if (r_ok) begin
                            if (type_q == CARD_SD) rca_q <= fld.new_rca;
                            state_q <= ST_CSD;
                        end else begin state_q <= ST_FAIL; fail_q <= FAIL_IDENT; end
                    end
                    ST_CSD: begin
                        if (r_ok) begin
                            blk_q   <= BLK_W'(1) << fld.blk_log2;
                            ver_q   <= (type_q == CARD_MMC) ? fld.mmc_ver : 3'd0;
                            state_q <= ST_SEL;
                        end else begin state_q <= ST_FAIL; fail_q <= FAIL_IDENT; end
                    end
                    ST_SEL: begin
                        if (r_ok) state_q <= ST_STAT;
                        else begin state_q <= ST_FAIL; fail_q <= FAIL_SELECT; end
                    end
                    ST_STAT: begin
                        if (!r_ok) begin
                            state_q <= ST_FAIL; fail_q <= FAIL_SELECT;
                        end else if (fld.stat_err) begin
                            state_q <= ST_FAIL; fail_q <= FAIL_STATUS;
                        end else if (fld.cur_state == TRAN_STATE) begin
                            state_q <= ST_DONE;
                        end
                    end
                    default: state_q <= ST_FAIL;
                endcase
            end
        end
    end

    assign busy      = running;
    assign done      = (state_q == ST_DONE);
    assign err_code  = fail_q;
    assign card_type = type_q;
    assign high_cap  = hc_q;
    assign rca       = rca_q;
    assign blk_len   = blk_q;
    assign mmc_ver   = ver_q;

endmodule

// File: rtl/sd_card_ident_chk.sv
module sd_card_ident_chk #(
    parameter int BLK_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [5:0]       cmd_index,
    input logic [31:0]      cmd_arg,
    input logic             rsp_valid,
    input logic             busy,
    input logic             done,
    input logic [3:0]       err_code,
    input logic [1:0]       card_type,
    input logic [15:0]      rca,
    input logic [BLK_W-1:0] blk_len
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) outst_q <= 1'b0;
        else if (cmd_valid && cmd_ready) outst_q <= 1'b1;
        else if (rsp_valid) outst_q <= 1'b0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!done && !busy && !cmd_valid && err_code == 4'd0));

    assert_cmd_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

    assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !outst_q);

    assert_done_no_error_R13: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_code == 4'd0));

    assert_done_holds_R13: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(rca) && $stable(blk_len)));

    assert_error_holds_R13: assert property (@(posedge clk) disable iff (rst)
        (err_code != 4'd0 && !start) |=> $stable(err_code));

    assert_blk_power_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(blk_len) == 1 && blk_len <= BLK_W'(512)));

    assert_type_known_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (card_type == 2'd1 || card_type == 2'd2));

endmodule

bind sd_card_ident sd_card_ident_chk #(.BLK_W(BLK_W)) i_chk (.*);

// File: tb/test_sd_card_ident.sv
module test_sd_card_ident;

    localparam int BLK_W = 10;
    localparam int K_SD2 = 0, K_SD1 = 1, K_MMC = 2, K_MMCBAD = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             cmd_valid;
    logic             cmd_ready = 1'b1;
    logic [5:0]       cmd_index;
    logic [31:0]      cmd_arg;
    logic             rsp_valid = 1'b0;
    logic [1:0]       rsp_code = 2'd0;
    logic [127:0]     rsp_data = '0;
    logic             busy, done, high_cap;
    logic [3:0]       err_code;
    logic [1:0]       card_type;
    logic [15:0]      rca;
    logic [BLK_W-1:0] blk_len;
    logic [2:0]       mmc_ver;

    int n_tests = 0;
    int n_fail  = 0;

    // card model configuration
    int          kind;
    int          busy_polls;
    bit          ccs;
    logic [15:0] m_rca;
    logic [3:0]  blk_f, ver_f;
    int          tran_polls;
    bit          stat_bad, cmd0_dead, csd_bad;
    int          op_seen, st_seen;
    logic [31:0] last_arg [64];
    int          cnt [64];
    int          seq [4];
    int          n_cmds;

    always #4 clk = ~clk;

    sd_card_ident #(.CLK_KHZ(1), .LIMIT_MS(3000)) i_sd_card_ident (
        .clk(clk), .rst(rst), .start(start),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
        .busy(busy), .done(done), .err_code(err_code),
        .card_type(card_type), .high_cap(high_cap), .rca(rca),
        .blk_len(blk_len), .mmc_ver(mmc_ver)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic answer(input logic [5:0] idx, output logic [1:0] code, output logic [127:0] d);
        bit b;
        code = 2'd0;
        d    = '0;
        case (idx)
            6'd0: if (cmd0_dead) code = 2'd1;
            6'd8: begin
                if (kind == K_SD2) d[31:0] = 32'h1AA;
                else if (kind == K_MMCBAD) d[31:0] = 32'h155;
                else code = 2'd1;
            end
            6'd55: ;
            6'd41, 6'd1: begin
                if (idx == 6'd41 && (kind == K_MMC || kind == K_MMCBAD)) code = 2'd1;
                else begin
                    op_seen++;
                    b = (op_seen > busy_polls);
                    d[31:0] = 32'h00FF_8000 | (b ? 32'h8000_0000 : 32'h0) | ((b && ccs) ? 32'h4000_0000 : 32'h0);
                end
            end
            6'd2: d[31:0] = 32'h1234_5678;
            6'd3: d[31:0] = {m_rca, 16'h0500};
            6'd9: begin
                if (csd_bad) code = 2'd2;
                else begin
                    d[75:72]   = blk_f;
                    d[117:114] = ver_f;
                end
            end
            6'd7: ;
            6'd13: begin
                st_seen++;
                d[12:9] = (st_seen > tran_polls) ? 4'd4 : 4'd3;
                if (stat_bad) d[19] = 1'b1;
            end
            default: code = 2'd2;
        endcase
    endtask

    // card model: answers each accepted command two cycles later
    initial begin
        logic [5:0]   idx;
        logic [1:0]   c;
        logic [127:0] d;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (cmd_valid && !rst) begin
                idx = cmd_index;
                last_arg[idx] = cmd_arg;
                cnt[idx]++;
                if (n_cmds < 4) seq[n_cmds] = int'(idx);
                n_cmds++;
                answer(idx, c, d);
                @(negedge clk);
                @(negedge clk);
                rsp_valid = 1'b1;
                rsp_code  = c;
                rsp_data  = d;
            end
        end
    end

    task automatic setup(input int k);
        kind = k; busy_polls = 0; ccs = 0; m_rca = 16'h0;
        blk_f = 4'd9; ver_f = 4'd0; tran_polls = 0;
        stat_bad = 0; cmd0_dead = 0; csd_bad = 0;
        op_seen = 0; st_seen = 0; n_cmds = 0;
        for (int i = 0; i < 64; i++) begin last_arg[i] = '0; cnt[i] = 0; end
        for (int i = 0; i < 4; i++) seq[i] = -1;
    endtask

    task automatic run_seq;
        int w;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        w = 0;
        while (!done && err_code == 4'd0 && w < 5000) begin
            @(negedge clk); w++;
        end
        if (w >= 5000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: sequence did not finish, actual busy expected idle");
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 done in reset", 32'(done), 0);
        chk("R1 err in reset", 32'(err_code), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 0);
        chk("R1 cmd_valid after reset", 32'(cmd_valid), 0);
    endtask

    task automatic t_sd_v2;
        setup(K_SD2);
        busy_polls = 2; ccs = 1; m_rca = 16'h1234; blk_f = 4'd9; tran_polls = 2;
        run_seq();
        chk("R2 first cmd", 32'(seq[0]), 0);
        chk("R2 reset arg", last_arg[0], 0);
        chk("R2 second cmd", 32'(seq[1]), 8);
        chk("R2 if-cond arg", last_arg[8], 32'h1AA);
        chk("R3 v2 op arg has HCS", last_arg[41], 32'h40FF_8000);
        chk("R4 app cmd count", 32'(cnt[55]), 3);
        chk("R4 app arg", last_arg[55], 0);
        chk("R4 sd op count", 32'(cnt[41]), 3);
        chk("R4 no mmc op", 32'(cnt[1]), 0);
        chk("R5 high cap", 32'(high_cap), 1);
        chk("R5 type SD", 32'(card_type), 1);
        chk("R6 cid arg", last_arg[2], 0);
        chk("R6 rca cmd arg", last_arg[3], 32'h0001_0000);
        chk("R6 sd rca", 32'(rca), 32'h1234);
        chk("R6 csd arg", last_arg[9], 32'h1234_0000);
        chk("R6 select arg", last_arg[7], 32'h1234_0000);
        chk("R6 status arg", last_arg[13], 32'h1234_0000);
        chk("R7 blk 512", 32'(blk_len), 512);
        chk("R7 sd ver zero", 32'(mmc_ver), 0);
        chk("R8 status polls", 32'(cnt[13]), 3);
        chk("R8 done", 32'(done), 1);
        chk("R13 no err", 32'(err_code), 0);
        @(negedge clk);
        chk("R13 done held", 32'(done), 1);
    endtask

    task automatic t_sd_v1;
        setup(K_SD1);
        busy_polls = 0; ccs = 0; m_rca = 16'hA5A5; blk_f = 4'd11;
        run_seq();
        chk("R3 v1 op arg no HCS", last_arg[41], 32'h00FF_8000);
        chk("R5 v1 not high cap", 32'(high_cap), 0);
        chk("R5 v1 type SD", 32'(card_type), 1);
        chk("R7 blk capped", 32'(blk_len), 512);
        chk("R6 v1 rca", 32'(rca), 32'hA5A5);
        chk("R8 v1 done", 32'(done), 1);
    endtask

    task automatic t_mmc;
        setup(K_MMC);
        busy_polls = 1; ccs = 1; m_rca = 16'hBEEF; blk_f = 4'd8; ver_f = 4'd6;
        run_seq();
        chk("R4 mmc reset resent", 32'(cnt[0]), 2);
        chk("R4 mmc op arg", last_arg[1], 32'h40FF_8000);
        chk("R4 mmc op count", 32'(cnt[1]), 2);
        chk("R5 mmc type", 32'(card_type), 2);
        chk("R5 mmc high cap", 32'(high_cap), 1);
        chk("R6 mmc keeps fixed rca", 32'(rca), 32'h0001);
        chk("R6 mmc select arg", last_arg[7], 32'h0001_0000);
        chk("R7 blk 256", 32'(blk_len), 256);
        chk("R7 mmc ver capped", 32'(mmc_ver), 4);
        chk("R8 mmc done", 32'(done), 1);
    endtask

    task automatic t_mmc_badecho;
        setup(K_MMCBAD);
        ver_f = 4'd2; blk_f = 4'd9;
        run_seq();
        chk("R3 bad echo skips sd op", 32'(cnt[41]), 0);
        chk("R3 bad echo skips app", 32'(cnt[55]), 0);
        chk("R3 bad echo mmc type", 32'(card_type), 2);
        chk("R7 mmc ver 2", 32'(mmc_ver), 2);
    endtask

    task automatic t_status_err;
        setup(K_SD2);
        stat_bad = 1;
        run_seq();
        chk("R9 status error code", 32'(err_code), 7);
        chk("R9 not done", 32'(done), 0);
        @(negedge clk);
        chk("R13 error held", 32'(err_code), 7);
    endtask

    task automatic t_reset_fail;
        setup(K_SD2);
        cmd0_dead = 1;
        run_seq();
        chk("R10 reset fail code", 32'(err_code), 1);
        chk("R10 stopped after reset", 32'(n_cmds), 1);
    endtask

    task automatic t_ident_fail;
        setup(K_SD2);
        csd_bad = 1;
        run_seq();
        chk("R10 ident fail code", 32'(err_code), 5);
        chk("R10 no select issued", 32'(cnt[7]), 0);
    endtask

    task automatic t_time_limit;
        setup(K_SD2);
        busy_polls = 1000000;
        run_seq();
        chk("R11 time limit code", 32'(err_code), 8);
        chk("R11 not busy", 32'(busy), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog: global time limit, actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        setup(K_SD2);
        t_reset();
        t_sd_v2();
        t_sd_v1();
        t_mmc();
        t_mmc_badecho();
        t_status_err();
        t_reset_fail();
        t_ident_fail();
        t_time_limit();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule